// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block takes a vector of interrupt request inputs and turns them into message-signalled interrupt writes. Each pin has a 64-bit redirection entry. The entry selects the vector, the delivery mode, the destination and its mode, the trigger style (edge or level) and a mask. A register front end loads the entries one 32-bit half at a time through a simple write port.

Edge pins latch a pending request on a rising input. Level pins follow their input, and after a delivery they are held back by a remote-acknowledge flag. An end-of-interrupt broadcast carrying the matching vector clears that flag. The engine scans eligible pins in ascending order from a rotating pointer. It presents one address/data message at a time on a valid/ready output.

The request on input 0 is routed to pin 2. Pin 0 never receives a request.

Top module: `irq_route_engine`

## Requirements
- R1: After reset every entry is masked and edge-triggered with no pending request, and `msgValid` is low. Rising inputs on masked pins then produce no message.
- R2: Input 0 drives pin 2, together with input 2. Every other input drives the pin with its own index, and pin 0 receives no request.
- R3: A rising input on an unmasked edge pin produces exactly one message. Holding the input high produces no further message.
- R4: A rising input on a masked edge pin is discarded. Unmasking that pin afterwards produces no message.
- R5: A level pin's pending state follows its input, whether the pin is masked or not. A masked level pin whose input is still high delivers once it is unmasked. One whose input has dropped before the unmask delivers nothing.
- R6: Delivering a level pin sets its remote-acknowledge flag. While the flag is set, the pin produces no new message, even if its input is held high or re-asserted.
- R7: An end-of-interrupt with vector V clears the remote-acknowledge flag of every entry whose vector equals V. If that pin is still pending and unmasked, it is delivered again. A vector that does not match has no effect.
- R8: After delivering pin p, the next message comes from the lowest eligible pin above p, wrapping to the lowest eligible pin overall. An eligible pin is one that is pending and unmasked, and for a level pin also has no remote acknowledge outstanding.
- R9: The message address is 0xFEE00000 with the destination in bits 19:12 and the destination mode in bit 2. The message data has the vector in bits 7:0, the delivery mode in bits 10:8 and the trigger mode in bit 15 (1 means level).
- R10: While `msgValid` is high and `msgReady` is low, the message is held unchanged. Each accepted handshake consumes one message.
- R11: The entry layout is as follows:
  - Low half (`cfgHigh`=0): vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11, remote acknowledge in bit 14, trigger in bit 15 (1 means level), mask in bit 16.
  - High half (`cfgHigh`=1): destination in bits 31:24.
  - The remote-acknowledge bit cannot be written. A low-half write that selects edge trigger clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_PINS | Interrupt request inputs |
| cfgWe | input | 1 | Entry write strobe |
| cfgPin | input | IDX_W | Entry index for the write |
| cfgHigh | input | 1 | 1 writes the upper 32 bits, 0 the lower 32 bits |
| cfgData | input | 32 | Write data for the selected half |
| eoiValid | input | 1 | End-of-interrupt broadcast strobe |
| eoiVector | input | 8 | Vector carried by the broadcast |
| msgValid | output | 1 | A message is presented |
| msgReady | input | 1 | The sink accepts the message |
| msgAddr | output | 32 | Message address |
| msgData | output | 32 | Message data |

## Verification
A change on `irqIn` reaches the pending state at the first clock edge. The message is captured at the second edge, so the bench drives inputs just after a falling edge and checks `msgValid` after two falling edges. Entry writes and end-of-interrupt strobes act at the first edge and can load a message at the second, so their results are sampled at the same distance. When `msgReady` stays high, each further eligible pin appears one cycle after the previous one. The ordering check therefore samples consecutive falling edges, and the stall check holds `msgReady` low over several edges before releasing it.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int PIN_IDX_MAX_W = 8;
  localparam logic [31:0] MSG_ADDR_BASE = 32'hFEE0_0000;

  // low-half field positions of an entry write
  localparam int F_DM_LSB  = 8;
  localparam int F_DMODE   = 11;
  localparam int F_TRIG    = 15;
  localparam int F_MASK    = 16;
  localparam int F_DEST_LSB = 24;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trigLevel;
    logic       destMode;
    logic [2:0] delivMode;
    logic [7:0] vector;
  } routeEntry_t;

  // control -> datapath: take the selected pin into the output register
  typedef struct packed {
    logic                     load;
    logic [PIN_IDX_MAX_W-1:0] pin;
  } svcStrobe_t;
endpackage

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS     = 24,
  parameter int REDIRECT_PIN = 2,
  localparam int IDX_W       = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] irqIn,
  input  logic                cfgWe,
  input  logic [IDX_W-1:0]    cfgPin,
  input  logic                cfgHigh,
  input  logic [31:0]         cfgData,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  input  svcStrobe_t          ctl,
  output logic [NUM_PINS-1:0] eligible,
  output logic [31:0]         msgAddr,
  output logic [31:0]         msgData
);
  localparam routeEntry_t RESET_ENTRY = '{dest: 8'd0, mask: 1'b1, trigLevel: 1'b0,
                                         destMode: 1'b0, delivMode: 3'd0, vector: 8'd0};

  routeEntry_t         entries [NUM_PINS];
  routeEntry_t         selEntry;
  logic [NUM_PINS-1:0] pinLvl, prevLvl, rise;
  logic [NUM_PINS-1:0] pending, pendNext;
  logic [NUM_PINS-1:0] remote, remoteNext;
  logic [NUM_PINS-1:0] capVec, eoiHit, cfgHit;

  // input-to-pin routing: input 0 is folded into the redirect pin
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pinMap
    if (g == 0) begin : g_zero
      assign pinLvl[g] = 1'b0;
    end else if (g == REDIRECT_PIN) begin : g_redir
      assign pinLvl[g] = irqIn[g] | irqIn[0];
    end else begin : g_direct
      assign pinLvl[g] = irqIn[g];
    end
  end

  assign rise = pinLvl & ~prevLvl;

  always_comb begin
    selEntry = RESET_ENTRY;
    for (int i = 0; i < NUM_PINS; i++) begin
      capVec[i]   = ctl.load && (ctl.pin == PIN_IDX_MAX_W'(i));
      cfgHit[i]   = cfgWe && (cfgPin == IDX_W'(i));
      eoiHit[i]   = eoiValid && remote[i] && (entries[i].vector == eoiVector);
      eligible[i] = pending[i] && !entries[i].mask && !(entries[i].trigLevel && remote[i]);
      if (entries[i].trigLevel) begin
        pendNext[i] = pinLvl[i];
      end else begin
        pendNext[i] = (pending[i] && !capVec[i]) || (rise[i] && !entries[i].mask);
      end
      remoteNext[i] = (remote[i] && !eoiHit[i]) || (capVec[i] && entries[i].trigLevel);
      if (cfgHit[i] && !cfgHigh && !cfgData[F_TRIG]) remoteNext[i] = 1'b0;
      if (capVec[i]) selEntry = entries[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PINS; i++) entries[i] <= RESET_ENTRY;
      pending <= '0;
      remote  <= '0;
      prevLvl <= '0;
      msgAddr <= '0;
      msgData <= '0;
    end else begin
      prevLvl <= pinLvl;
      pending <= pendNext;
      remote  <= remoteNext;
      for (int i = 0; i < NUM_PINS; i++) begin
        if (cfgHit[i]) begin
          if (cfgHigh) begin
            entries[i].dest <= cfgData[F_DEST_LSB +: 8];
          end else begin
            entries[i].vector    <= cfgData[7:0];
            entries[i].delivMode <= cfgData[F_DM_LSB +: 3];
            entries[i].destMode  <= cfgData[F_DMODE];
            entries[i].trigLevel <= cfgData[F_TRIG];
            entries[i].mask      <= cfgData[F_MASK];
          end
        end
      end
      if (ctl.load) begin
        msgAddr <= MSG_ADDR_BASE | (32'(selEntry.dest) << 12) | (32'(selEntry.destMode) << 2);
        msgData <= 32'(selEntry.vector) | (32'(selEntry.delivMode) << 8)
                 | (32'(selEntry.trigLevel) << 15);
      end
    end
  end

  // R4: the control never takes a masked pin
  a_r4_masked_not_served: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> !selEntry.mask);
  // R6: a level pin with an outstanding acknowledge is never taken
  a_r6_no_redeliver: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> !(selEntry.trigLevel && |(capVec & remote)));
  // R6: taking a level pin leaves its acknowledge flag set
  a_r6_remote_set: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && selEntry.trigLevel && !cfgWe) |=> |($past(capVec) & remote));
endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] eligible,
  input  logic                msgReady,
  output logic                msgValid,
  output svcStrobe_t          ctl
);
  logic [IDX_W-1:0]    scanPtr, pick;
  logic [NUM_PINS-1:0] aboveMask, cand;
  logic                canLoad;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) aboveMask[i] = (i >= int'(scanPtr));
    cand = (|(eligible & aboveMask)) ? (eligible & aboveMask) : eligible;
    pick = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (cand[i]) pick = IDX_W'(i);
    end
    canLoad  = !msgValid || msgReady;
    ctl.load = canLoad && (|eligible);
    ctl.pin  = PIN_IDX_MAX_W'(pick);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid <= 1'b0;
      scanPtr  <= '0;
    end else begin
      if (ctl.load) begin
        msgValid <= 1'b1;
        scanPtr  <= (pick == IDX_W'(NUM_PINS - 1)) ? '0 : pick + 1'b1;
      end else if (msgReady) begin
        msgValid <= 1'b0;
      end
    end
  end

  // R8: whatever is taken was eligible
  a_r8_pick_eligible: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> |(eligible & (NUM_PINS'(1) << ctl.pin)));
  // R10: nothing is taken while the sink holds off
  a_r10_no_load_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |-> !ctl.load);
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS     = 24,
  parameter int REDIRECT_PIN = 2,
  localparam int IDX_W       = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] irqIn,
  input  logic                cfgWe,
  input  logic [IDX_W-1:0]    cfgPin,
  input  logic                cfgHigh,
  input  logic [31:0]         cfgData,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  output logic                msgValid,
  input  logic                msgReady,
  output logic [31:0]         msgAddr,
  output logic [31:0]         msgData
);
  svcStrobe_t          ctl;
  logic [NUM_PINS-1:0] eligible;

  irq_route_dp #(.NUM_PINS(NUM_PINS), .REDIRECT_PIN(REDIRECT_PIN)) u_dp (
    .clk, .rstN, .irqIn, .cfgWe, .cfgPin, .cfgHigh, .cfgData,
    .eoiValid, .eoiVector, .ctl, .eligible, .msgAddr, .msgData
  );

  irq_route_ctl #(.NUM_PINS(NUM_PINS)) u_ctl (
    .clk, .rstN, .eligible, .msgReady, .msgValid, .ctl
  );

  // R10: a presented message stays put until accepted
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData)));
endmodule

// File: tb/test_irq_route_engine.sv
module test_irq_route_engine;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rstN;
  logic [N-1:0] irqIn;
  logic        cfgWe, cfgHigh, eoiValid, msgReady;
  logic [4:0]  cfgPin;
  logic [31:0] cfgData;
  logic [7:0]  eoiVector;
  logic        msgValid;
  logic [31:0] msgAddr, msgData;
  int nChecks = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  irq_route_engine i_irq_route_engine (
    .clk, .rstN, .irqIn, .cfgWe, .cfgPin, .cfgHigh, .cfgData,
    .eoiValid, .eoiVector, .msgValid, .msgReady, .msgAddr, .msgData
  );

  typedef struct packed {
    logic [4:0] pin;
    logic [7:0] vec;
    logic [2:0] dm;
    logic       dmode;
    logic [7:0] dest;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{5'd1,  8'h31, 3'd0, 1'b0, 8'h01},
    '{5'd3,  8'h33, 3'd1, 1'b1, 8'hA5},
    '{5'd7,  8'h37, 3'd2, 1'b0, 8'hFF},
    '{5'd12, 8'h3C, 3'd4, 1'b1, 8'h10},
    '{5'd23, 8'h57, 3'd7, 1'b0, 8'h80},
    '{5'd17, 8'h51, 3'd5, 1'b1, 8'h3E}
  };

  function automatic logic [31:0] lowWord(logic [7:0] vec, logic [2:0] dm, logic dmode,
                                          logic rem, logic lvl, logic msk);
    return {15'd0, msk, lvl, rem, 2'b00, dmode, dm, vec};
  endfunction

  function automatic logic [31:0] expAddr(logic [7:0] dest, logic dmode);
    return 32'hFEE0_0000 | ({24'd0, dest} << 12) | ({31'd0, dmode} << 2);
  endfunction

  function automatic logic [31:0] expData(logic [7:0] vec, logic [2:0] dm, logic lvl);
    return {24'd0, vec} | ({29'd0, dm} << 8) | ({31'd0, lvl} << 15);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s got %h exp %h", req, what, act, exp);
    end
  endtask

  task automatic expectMsg(logic [31:0] a, logic [31:0] d, string req);
    check(msgValid === 1'b1, req, "valid", {31'd0, msgValid}, 32'd1);
    check(msgAddr === a, req, "addr", msgAddr, a);
    check(msgData === d, req, "data", msgData, d);
  endtask

  task automatic expectQuiet(int n, string req);
    repeat (n) begin
      tick();
      check(msgValid === 1'b0, req, "quiet", {31'd0, msgValid}, 32'd0);
    end
  endtask

  task automatic writeEntry(int pin, logic high, logic [31:0] d);
    cfgWe = 1'b1; cfgPin = 5'(pin); cfgHigh = high; cfgData = d;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic sendEoi(logic [7:0] v);
    eoiValid = 1'b1; eoiVector = v;
    tick();
    eoiValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    rstN = 1'b0; irqIn = '0; cfgWe = 1'b0; cfgPin = '0; cfgHigh = 1'b0;
    cfgData = '0; eoiValid = 1'b0; eoiVector = '0; msgReady = 1'b1;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1: reset state, all masked
    check(msgValid === 1'b0, "R1", "reset valid", {31'd0, msgValid}, 32'd0);
    irqIn = '1;
    expectQuiet(4, "R1");
    irqIn = '0;
    tick();

    // R9: encoding table, edge pins
    for (int k = 0; k < 6; k++) begin
      writeEntry(ROWS[k].pin, 1'b1, {ROWS[k].dest, 24'd0});
      writeEntry(ROWS[k].pin, 1'b0, lowWord(ROWS[k].vec, ROWS[k].dm, ROWS[k].dmode, 1'b0, 1'b0, 1'b0));
      irqIn[ROWS[k].pin] = 1'b1;
      tick(); tick();
      expectMsg(expAddr(ROWS[k].dest, ROWS[k].dmode), expData(ROWS[k].vec, ROWS[k].dm, 1'b0), "R9");
      irqIn[ROWS[k].pin] = 1'b0;
      expectQuiet(1, "R9");
      writeEntry(ROWS[k].pin, 1'b0, lowWord(ROWS[k].vec, ROWS[k].dm, ROWS[k].dmode, 1'b0, 1'b0, 1'b1));
    end

    // R2: input 0 lands on pin 2, pin 0 never fires
    writeEntry(2, 1'b0, lowWord(8'h42, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    writeEntry(0, 1'b0, lowWord(8'h40, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    irqIn[0] = 1'b1;
    tick(); tick();
    expectMsg(expAddr(8'h00, 1'b0), expData(8'h42, 3'd0, 1'b0), "R2");
    expectQuiet(3, "R2");
    irqIn[0] = 1'b0;
    tick();

    // R4: masked edge discarded
    writeEntry(4, 1'b0, lowWord(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
    irqIn[4] = 1'b1;
    tick(); tick();
    writeEntry(4, 1'b0, lowWord(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    expectQuiet(4, "R4");
    irqIn[4] = 1'b0;
    tick();

    // R3: single delivery while held high
    writeEntry(6, 1'b0, lowWord(8'h46, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    irqIn[6] = 1'b1;
    tick(); tick();
    expectMsg(expAddr(8'h00, 1'b0), expData(8'h46, 3'd0, 1'b0), "R3");
    expectQuiet(5, "R3");
    irqIn[6] = 1'b0;
    expectQuiet(2, "R3");

    // R6 / R7: level pin 9
    writeEntry(9, 1'b0, lowWord(8'h59, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    irqIn[9] = 1'b1;
    tick(); tick();
    expectMsg(expAddr(8'h00, 1'b0), expData(8'h59, 3'd0, 1'b1), "R6");
    expectQuiet(4, "R6");
    irqIn[9] = 1'b0;
    tick();
    irqIn[9] = 1'b1;
    expectQuiet(4, "R6");
    sendEoi(8'h58);
    expectQuiet(3, "R7");
    sendEoi(8'h59);
    tick();
    expectMsg(expAddr(8'h00, 1'b0), expData(8'h59, 3'd0, 1'b1), "R7");
    irqIn[9] = 1'b0;
    tick();
    sendEoi(8'h59);
    expectQuiet(3, "R5");

    // R5: masked level delivers on unmask while high
    writeEntry(10, 1'b0, lowWord(8'h5A, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1));
    irqIn[10] = 1'b1;
    expectQuiet(3, "R5");
    writeEntry(10, 1'b0, lowWord(8'h5A, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    tick();
    expectMsg(expAddr(8'h00, 1'b0), expData(8'h5A, 3'd0, 1'b1), "R5");
    irqIn[10] = 1'b0;
    tick();
    writeEntry(11, 1'b0, lowWord(8'h5B, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1));
    irqIn[11] = 1'b1;
    tick(); tick();
    irqIn[11] = 1'b0;
    tick(); tick();
    writeEntry(11, 1'b0, lowWord(8'h5B, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    expectQuiet(4, "R5");

    // R11: remote bit read-only, edge write clears it
    writeEntry(13, 1'b0, lowWord(8'h5D, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    irqIn[13] = 1'b1;
    tick(); tick();
    expectMsg(expAddr(8'h00, 1'b0), expData(8'h5D, 3'd0, 1'b1), "R11");
    writeEntry(13, 1'b0, lowWord(8'h5D, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    expectQuiet(4, "R11");
    writeEntry(13, 1'b0, lowWord(8'h5D, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1));
    writeEntry(13, 1'b0, lowWord(8'h5D, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    tick();
    expectMsg(expAddr(8'h00, 1'b0), expData(8'h5D, 3'd0, 1'b1), "R11");
    irqIn[13] = 1'b0;
    tick();
    writeEntry(14, 1'b0, lowWord(8'h5E, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0));
    irqIn[14] = 1'b1;
    tick(); tick();
    expectMsg(expAddr(8'h00, 1'b0), expData(8'h5E, 3'd0, 1'b1), "R11");
    irqIn[14] = 1'b0;
    tick();

    // R8: scan resumes above pin 14 and wraps
    writeEntry(3,  1'b0, lowWord(8'h63, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    writeEntry(8,  1'b0, lowWord(8'h68, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    writeEntry(15, 1'b0, lowWord(8'h6F, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    writeEntry(20, 1'b0, lowWord(8'h74, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    irqIn[3] = 1'b1; irqIn[8] = 1'b1; irqIn[15] = 1'b1; irqIn[20] = 1'b1;
    tick(); tick();
    expectMsg(expAddr(8'h00, 1'b0), expData(8'h6F, 3'd0, 1'b0), "R8");
    tick();
    expectMsg(expAddr(8'h00, 1'b0), expData(8'h74, 3'd0, 1'b0), "R8");
    tick();
    expectMsg(expAddr(8'hA5, 1'b0), expData(8'h63, 3'd0, 1'b0), "R8");
    tick();
    expectMsg(expAddr(8'h00, 1'b0), expData(8'h68, 3'd0, 1'b0), "R8");
    expectQuiet(2, "R8");
    irqIn = '0;
    tick();

    // R10: stall holds the message
    writeEntry(1, 1'b0, lowWord(8'h71, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    writeEntry(5, 1'b0, lowWord(8'h75, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    msgReady = 1'b0;
    irqIn[1] = 1'b1; irqIn[5] = 1'b1;
    tick(); tick();
    expectMsg(expAddr(8'h01, 1'b0), expData(8'h71, 3'd0, 1'b0), "R10");
    tick();
    expectMsg(expAddr(8'h01, 1'b0), expData(8'h71, 3'd0, 1'b0), "R10");
    tick();
    expectMsg(expAddr(8'h01, 1'b0), expData(8'h71, 3'd0, 1'b0), "R10");
    msgReady = 1'b1;
    tick();
    expectMsg(expAddr(8'h00, 1'b0), expData(8'h75, 3'd0, 1'b0), "R10");
    expectQuiet(2, "R10");
    irqIn = '0;
    tick();

    // R2: input 2 also drives pin 2
    irqIn[2] = 1'b1;
    tick(); tick();
    expectMsg(expAddr(8'h00, 1'b0), expData(8'h42, 3'd0, 1'b0), "R2");
    irqIn[2] = 1'b0;
    expectQuiet(2, "R2");

    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule